// File: doc/BRIEF.md
# Subword-Parallel Multiply-Add Unit

This functional unit combines two 16-bit signed operands by multiplying or adding them. In word mode it performs one signed 16-bit operation and gives a 32-bit result. In subword mode each operand splits into a high byte and a low byte. Two independent signed 8-bit operations then run side by side, and each lane writes its own 16-bit half of the output. Before the result leaves the unit, an arithmetic right shift scales it. Saturation can then clamp it, all within the same cycle.

The unit has three multipliers: one 16x16 for word mode and two 8x8 for the subword lanes. Add operations share each multiplier's adder path through a select. The operands for the word multiplier and for the lane multipliers sit in separate hold registers. Each set loads only when an operation of its own mode is issued, so the datapath that is not in use sees no toggling. These hold registers, together with a configuration register, form the single register stage of the unit. A result is therefore presented one cycle after its operation is issued, and it stays on the output until the next operation.

Top module: `swp_mac_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` is 0 and `result` is 0.
- R2: The unit captures operands and the mode controls only in a cycle where `in_valid` is high. `out_valid` is high in exactly the cycle after each such cycle, including back-to-back issues. The word operand registers load only on word-mode issues, and the lane operand registers load only on subword issues.
- R3: Word multiply (`sub_mode`=0, `use_add`=0) returns the signed 32-bit product of `op_a` and `op_b`.
- R4: Word add (`sub_mode`=0, `use_add`=1) returns the signed sum of `op_a` and `op_b`, sign-extended to 32 bits.
- R5: Subword multiply (`sub_mode`=1, `use_add`=0) places the signed product of `op_a[15:8]` and `op_b[15:8]` in `result[31:16]`. It places the signed product of `op_a[7:0]` and `op_b[7:0]` in `result[15:0]`.
- R6: Subword add (`sub_mode`=1, `use_add`=1) places the signed sum of the high bytes in `result[31:16]`. It places the signed sum of the low bytes in `result[15:0]`. Each sum is sign-extended to 16 bits.
- R7: `shamt` (0 to 15) applies an arithmetic right shift to the word result, or to each lane result separately. The shift is applied before saturation.
- R8: When `sat_en` is 1, a word result is clamped to [-32768, 32767] and sign-extended to 32 bits. Each lane result is clamped to [-128, 127] and sign-extended to 16 bits. When `sat_en` is 0, no clamping is applied.
- R9: While `in_valid` is low, `result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issues an operation this cycle |
| op_a | input | 16 | First operand (two bytes in subword mode) |
| op_b | input | 16 | Second operand (two bytes in subword mode) |
| use_add | input | 1 | 1 = add, 0 = multiply |
| sub_mode | input | 1 | 1 = two 8-bit lanes, 0 = one 16-bit word |
| sat_en | input | 1 | Enables saturation after the shift |
| shamt | input | 4 | Arithmetic right shift amount |
| out_valid | output | 1 | Result of the previous cycle's issue is present |
| result | output | 32 | Scaled, optionally saturated result |

## Verification
Every result is due exactly one cycle after its issue. Inputs are driven on the falling edge. The rising edge that follows captures them, so the matching output is checked shortly after that edge. The monitor pairs each `out_valid` pulse with the oldest expected value in the queue. Any pulse that arrives with an empty queue, or any expectation still queued at the end, therefore shows a latency or pulse-count error. The hold behaviour is checked several idle cycles after an issue, against the last expected value.

// File: rtl/swp_pkg.sv
package swp_pkg;

    localparam int DATA_W = 16;
    localparam int SH_W   = 4;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_ADD = 1'b1
    } op_kind_e;

    typedef struct packed {
        op_kind_e          kind;
        logic              sub_mode;
        logic              sat_en;
        logic [SH_W-1:0]   shamt;
    } cfg_t;

endpackage

// File: rtl/swp_operand_hold.sv
module swp_operand_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d_a,
    input  logic [W-1:0] d_b,
    output logic [W-1:0] q_a,
    output logic [W-1:0] q_b
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_a <= '0;
            q_b <= '0;
        end else if (en) begin
            q_a <= d_a;
            q_b <= d_b;
        end
    end

endmodule

// File: rtl/swp_lane_arith.sv
module swp_lane_arith
    import swp_pkg::*;
#(
    parameter int W = 16,
    localparam int YW = 2 * W
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  op_kind_e      kind,
    output logic [YW-1:0] y
);

    logic signed [YW-1:0] ax;
    logic signed [YW-1:0] bx;
    logic signed [YW-1:0] prod;
    logic signed [YW-1:0] sum;

    always_comb begin
        ax   = {{W{a[W-1]}}, a};
        bx   = {{W{b[W-1]}}, b};
        prod = ax * bx;
        sum  = ax + bx;
        y    = (kind == OP_ADD) ? sum : prod;
    end

endmodule

// File: rtl/swp_scale_sat.sv
module swp_scale_sat #(
    parameter int IW  = 32,
    parameter int SW  = 16,
    parameter int SHW = 4
) (
    input  logic [IW-1:0]  x,
    input  logic [SHW-1:0] shamt,
    input  logic           sat_en,
    output logic [IW-1:0]  y
);

    localparam logic signed [IW-1:0] MAXV = {{(IW-SW+1){1'b0}}, {(SW-1){1'b1}}};
    localparam logic signed [IW-1:0] MINV = {{(IW-SW+1){1'b1}}, {(SW-1){1'b0}}};

    logic signed [IW-1:0] shifted;

    always_comb begin
        shifted = $signed(x) >>> shamt;
        if (sat_en && (shifted > MAXV)) begin
            y = MAXV;
        end else if (sat_en && (shifted < MINV)) begin
            y = MINV;
        end else begin
            y = shifted;
        end
    end

endmodule

// File: rtl/swp_mac_unit.sv
module swp_mac_unit
    import swp_pkg::*;
#(
    parameter int DW = swp_pkg::DATA_W,
    parameter int SHW = swp_pkg::SH_W,
    localparam int LW = DW / 2,
    localparam int RW = 2 * DW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [DW-1:0]  op_a,
    input  logic [DW-1:0]  op_b,
    input  logic           use_add,
    input  logic           sub_mode,
    input  logic           sat_en,
    input  logic [SHW-1:0] shamt,
    output logic           out_valid,
    output logic [RW-1:0]  result
);

    cfg_t          cfg_q;
    logic          valid_q;
    logic          word_en;
    logic          lane_en;
    logic          sub_q;
    logic          sat_q;
    logic [DW-1:0] word_a_q;
    logic [DW-1:0] word_b_q;
    logic [DW-1:0] lane_a_q;
    logic [DW-1:0] lane_b_q;
    logic [RW-1:0] word_raw;
    logic [RW-1:0] word_y;
    logic [DW-1:0] lane_y [2];

    assign word_en = in_valid && !sub_mode;
    assign lane_en = in_valid && sub_mode;
    assign sub_q   = cfg_q.sub_mode;
    assign sat_q   = cfg_q.sat_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                cfg_q.kind     <= use_add ? OP_ADD : OP_MUL;
                cfg_q.sub_mode <= sub_mode;
                cfg_q.sat_en   <= sat_en;
                cfg_q.shamt    <= shamt;
            end
        end
    end

    swp_operand_hold #(.W(DW)) word_hold_i (
        .clk (clk),
        .rst (rst),
        .en  (word_en),
        .d_a (op_a),
        .d_b (op_b),
        .q_a (word_a_q),
        .q_b (word_b_q)
    );

    swp_operand_hold #(.W(DW)) lane_hold_i (
        .clk (clk),
        .rst (rst),
        .en  (lane_en),
        .d_a (op_a),
        .d_b (op_b),
        .q_a (lane_a_q),
        .q_b (lane_b_q)
    );

    swp_lane_arith #(.W(DW)) word_arith_i (
        .a    (word_a_q),
        .b    (word_b_q),
        .kind (cfg_q.kind),
        .y    (word_raw)
    );

    swp_scale_sat #(.IW(RW), .SW(DW), .SHW(SHW)) word_scale_i (
        .x      (word_raw),
        .shamt  (cfg_q.shamt),
        .sat_en (cfg_q.sat_en),
        .y      (word_y)
    );

    for (genvar l = 0; l < 2; l++) begin : g_lane
        logic [DW-1:0] raw;

        swp_lane_arith #(.W(LW)) arith_i (
            .a    (lane_a_q[l*LW +: LW]),
            .b    (lane_b_q[l*LW +: LW]),
            .kind (cfg_q.kind),
            .y    (raw)
        );

        swp_scale_sat #(.IW(DW), .SW(LW), .SHW(SHW)) scale_i (
            .x      (raw),
            .shamt  (cfg_q.shamt),
            .sat_en (cfg_q.sat_en),
            .y      (lane_y[l])
        );
    end

    assign out_valid = valid_q;
    assign result    = cfg_q.sub_mode ? {lane_y[1], lane_y[0]} : word_y;

endmodule

// File: rtl/swp_mac_chk.sv
module swp_mac_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        sub_mode,
    input logic        out_valid,
    input logic [31:0] result,
    input logic [15:0] word_a_q,
    input logic [15:0] word_b_q,
    input logic [15:0] lane_a_q,
    input logic [15:0] lane_b_q,
    input logic        sub_q,
    input logic        sat_q
);

    // R2
    issue_valid_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2
    word_iso_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && !sub_mode) |=> ($stable(word_a_q) && $stable(word_b_q)));

    // R2
    lane_iso_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && sub_mode) |=> ($stable(lane_a_q) && $stable(lane_b_q)));

    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    // R8
    word_sat_range_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sat_q && !sub_q) |-> ((result[31:15] == '0) || (result[31:15] == '1)));

    // R8
    lane_sat_range_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sat_q && sub_q) |->
        (((result[31:23] == '0) || (result[31:23] == '1)) &&
         ((result[15:7] == '0) || (result[15:7] == '1))));

endmodule

bind swp_mac_unit swp_mac_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .sub_mode  (sub_mode),
    .out_valid (out_valid),
    .result    (result),
    .word_a_q  (word_a_q),
    .word_b_q  (word_b_q),
    .lane_a_q  (lane_a_q),
    .lane_b_q  (lane_b_q),
    .sub_q     (sub_q),
    .sat_q     (sat_q)
);

// File: tb/swp_mac_unit_tb.sv
module swp_mac_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        use_add = 1'b0;
    logic        sub_mode = 1'b0;
    logic        sat_en = 1'b0;
    logic [3:0]  shamt = '0;
    logic        out_valid;
    logic [31:0] result;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic [31:0] last_exp = '0;

    always #5 clk = ~clk;

    swp_mac_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .use_add   (use_add),
        .sub_mode  (sub_mode),
        .sat_en    (sat_en),
        .shamt     (shamt),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic longint clamp(longint v, longint lo, longint hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic logic [31:0] model(logic [15:0] a, logic [15:0] b,
                                          bit add, bit sub, bit sat, int sh);
        longint p, ph, pl;
        logic [31:0] r;
        if (!sub) begin
            p = add ? (longint'($signed(a)) + longint'($signed(b)))
                    : (longint'($signed(a)) * longint'($signed(b)));
            p = p >>> sh;
            if (sat) p = clamp(p, -32768, 32767);
            r = p[31:0];
        end else begin
            ph = add ? (longint'($signed(a[15:8])) + longint'($signed(b[15:8])))
                     : (longint'($signed(a[15:8])) * longint'($signed(b[15:8])));
            pl = add ? (longint'($signed(a[7:0])) + longint'($signed(b[7:0])))
                     : (longint'($signed(a[7:0])) * longint'($signed(b[7:0])));
            ph = ph >>> sh;
            pl = pl >>> sh;
            if (sat) begin
                ph = clamp(ph, -128, 127);
                pl = clamp(pl, -128, 127);
            end
            r = {ph[15:0], pl[15:0]};
        end
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(logic [15:0] a, logic [15:0] b, bit add, bit sub,
                         bit sat, int sh, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        op_a     = a;
        op_b     = b;
        use_add  = add;
        sub_mode = sub;
        sat_en   = sat;
        shamt    = 4'(sh);
        exp_q.push_back(model(a, b, add, sub, sat, sh));
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_a     = 16'hA5C3;
            op_b     = 16'h3C5A;
            use_add  = ~use_add;
            sub_mode = ~sub_mode;
        end
    endtask

    // Monitor: results are due one edge after the issuing edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst && out_valid) begin
                if (exp_q.size() == 0) begin
                    total++;
                    bad++;
                    $display("FAIL R2: actual=out_valid with no issue expected=none");
                end else begin
                    last_exp = exp_q.pop_front();
                    check(tag_q.pop_front(), result, last_exp);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", {31'b0, out_valid}, 32'd0);
        check("R1 result in reset", result, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid after reset", {31'b0, out_valid}, 32'd0);
        check("R1 result after reset", result, 32'd0);

        issue(16'd300, -16'sd7, 0, 0, 0, 0, "R3 word mul mixed sign");
        issue(16'h8000, 16'h8000, 0, 0, 0, 0, "R3 word mul min*min");
        issue(16'h7FFF, 16'h7FFF, 0, 0, 0, 0, "R3 word mul max*max");
        issue(16'h8000, 16'h8000, 1, 0, 0, 0, "R4 word add min+min");
        issue(16'd1234, 16'd4321, 1, 0, 0, 0, "R4 word add positive");
        issue(16'h8005, 16'h80FD, 0, 1, 0, 0, "R5 lane mul");
        issue(16'h7F80, 16'h7F80, 1, 1, 0, 0, "R6 lane add extremes");
        issue(16'h03FF, 16'hFC01, 1, 1, 0, 0, "R6 lane add carry isolation");
        issue(16'd1000, -16'sd3, 0, 0, 0, 4, "R7 word shift negative");
        issue(16'h8000, 16'h8000, 0, 0, 0, 15, "R7 word shift 15");
        issue(16'h8005, 16'h80FD, 0, 1, 0, 3, "R7 lane shift");
        issue(16'h8000, 16'h8000, 0, 0, 1, 0, "R8 word sat high");
        issue(16'h8000, 16'h8000, 1, 0, 1, 0, "R8 word sat low");
        issue(16'h8005, 16'h80FD, 0, 1, 1, 0, "R8 lane sat");
        issue(16'h8000, 16'h8000, 0, 0, 1, 15, "R8 shift before sat");
        issue(16'd1000, 16'd30, 0, 0, 1, 0, "R8 in-range no clamp");
        issue(16'h8000, 16'h8000, 0, 0, 0, 0, "R8 sat off no clamp");
        idle(4);
        check("R9 result held", result, last_exp);
        check("R2 pending after idle", 32'(exp_q.size()), 32'd0);

        for (int i = 0; i < 40; i++) begin
            logic [15:0] a, b;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = lfsr;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            b = lfsr ^ 16'h5A5A;
            issue(a, b, a[0], a[1], b[2], int'(b[7:4]), "R2 mixed stream");
            if (i % 7 == 3) idle(1);
        end
        idle(3);
        check("R9 result held after stream", result, last_exp);
        check("R2 all results delivered", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule